// File: doc/BRIEF.md
# Iterative ChaCha Block Core

This core evaluates the ChaCha block function on a 4x4 matrix of 32-bit words. A one-cycle `start` pulse loads the 512-bit input matrix into a working state and also into a saved copy. The core then repeats double rounds until the requested round count is used up. Each double round is a column round followed by a diagonal round, and each round takes one clock cycle. Four quarter-round lanes, one per column, do all of the arithmetic. The diagonal round uses the same four lanes: rows b, c and d are first rotated within their own words, and the rotation is undone once the lanes have finished.

When the last diagonal round ends, the core adds the saved input to the final state word by word. It registers the sum on `blk_out` and raises `done` for one cycle. Key setup, nonce and counter handling, and XOR with plaintext are left to the surrounding logic.

Top module: `chacha_core`

## Requirements
- R1: Word i of the matrix (i = 0..15) occupies bits [32i+31:32i] of `blk_in` and `blk_out`. Row a is words 0-3, row b is words 4-7, row c is words 8-11 and row d is words 12-15. Column j holds words j, 4+j, 8+j and 12+j. Output word i is the final state word i plus input word i, modulo 2^32.
- R2: A quarter round on (a,b,c,d) runs these steps in order: a+=b, d^=a, d rotated left by 16; c+=d, b^=c, b rotated left by 12; a+=b, d^=a, d rotated left by 8; c+=d, b^=c, b rotated left by 7. All additions are modulo 2^32.
- R3: A double round is a column round on all four columns at once, followed by a diagonal round. In the diagonal round the quarter round acts on word groups (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14), and every word then goes back to its home position.
- R4: The number of double rounds is 1 when `rounds` is 2 or less, and ceil(`rounds`/2) otherwise. Values 0, 1 and 2 therefore give identical outputs, and so do 3 and 4.
- R5: `done` goes high for exactly one cycle, 2×(number of double rounds) clock edges after the edge that accepts `start`. It stays low at all other times.
- R6: A `start` pulse that arrives while a block is being computed has no effect. The running block finishes with its own result at its own time, and no extra `done` follows.
- R7: Reset clears `blk_out` and `done`. `blk_out` holds its value from one completion until the next.
- R8: With 20 rounds and the standard published block-function test vector as input, the output matches the published result. Round counts of 8, 12 and 20 give three different outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a block when the core is idle |
| rounds | input | ROUND_W | Round count, consumed two per double round |
| blk_in | input | 512 | Input matrix, word i at bits [32i+31:32i] |
| blk_out | output | 512 | Registered result matrix |
| done | output | 1 | One-cycle pulse when `blk_out` is updated |

## Verification
The only result is `blk_out` together with `done`. Both are due exactly 2×N clock edges after the accepting edge, where N is the double-round count computed from `rounds` as in R4. The bench drives inputs on falling edges, counts falling edges from the accepting edge, and samples `done` and `blk_out` at the falling edge that follows the completing edge. Each completion must arrive at the cycle predicted for it, and the bench also compares the output against a bench model of the block function.

// File: rtl/chacha_pkg.sv
package chacha_pkg;
  localparam int WORD_W = 32;
  localparam int ROWS   = 4;
  localparam int COLS   = 4;
  localparam int BLK_W  = WORD_W * ROWS * COLS;

  typedef logic [WORD_W-1:0]     word_t;
  typedef word_t [COLS-1:0]      row_t;
  typedef row_t  [ROWS-1:0]      mat_t;

  function automatic word_t rotl(input word_t v, input int unsigned n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/chacha_qr_lane.sv
module chacha_qr_lane
  import chacha_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1, a2, b2, c2, d2;

  always_comb begin
    a1 = a_i + b_i;
    d1 = rotl(d_i ^ a1, 16);
    c1 = c_i + d1;
    b1 = rotl(b_i ^ c1, 12);
    a2 = a1 + b1;
    d2 = rotl(d1 ^ a2, 8);
    c2 = c1 + d2;
    b2 = rotl(b1 ^ c2, 7);
  end

  assign a_o = a2;
  assign b_o = b2;
  assign c_o = c2;
  assign d_o = d2;
endmodule

// File: rtl/chacha_row_shift.sv
module chacha_row_shift
  import chacha_pkg::*;
#(
  parameter int SHIFT   = 0,
  parameter bit INVERSE = 1'b0
) (
  input  row_t row_i,
  output row_t row_o
);
  localparam int STEP = INVERSE ? (COLS - (SHIFT % COLS)) % COLS : SHIFT % COLS;

  for (genvar j = 0; j < COLS; j++) begin : g_word
    assign row_o[j] = row_i[(j + STEP) % COLS];
  end
endmodule

// File: rtl/chacha_core.sv
module chacha_core
  import chacha_pkg::*;
#(
  parameter int ROUND_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [ROUND_W-1:0] rounds,
  input  logic [BLK_W-1:0]   blk_in,
  output logic [BLK_W-1:0]   blk_out,
  output logic               done
);
  localparam logic [ROUND_W-1:0] DR_STEP = ROUND_W'(2);

  mat_t               st_q, saved_q, out_q;
  logic               busy_q, diag_q, done_q;
  logic [ROUND_W-1:0] cnt_q;

  mat_t fwd_rows, pre_rows, lane_rows, back_rows, nxt_st, sum_st;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    chacha_row_shift #(.SHIFT(r), .INVERSE(1'b0)) u_fwd (
      .row_i(st_q[r]), .row_o(fwd_rows[r]));
    chacha_row_shift #(.SHIFT(r), .INVERSE(1'b1)) u_back (
      .row_i(lane_rows[r]), .row_o(back_rows[r]));
    assign pre_rows[r] = diag_q ? fwd_rows[r] : st_q[r];
    assign nxt_st[r]   = diag_q ? back_rows[r] : lane_rows[r];
    for (genvar j = 0; j < COLS; j++) begin : g_sum
      assign sum_st[r][j] = nxt_st[r][j] + saved_q[r][j];
    end
  end

  for (genvar j = 0; j < COLS; j++) begin : g_lane
    chacha_qr_lane u_lane (
      .a_i(pre_rows[0][j]),  .b_i(pre_rows[1][j]),
      .c_i(pre_rows[2][j]),  .d_i(pre_rows[3][j]),
      .a_o(lane_rows[0][j]), .b_o(lane_rows[1][j]),
      .c_o(lane_rows[2][j]), .d_o(lane_rows[3][j]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= '0;
      saved_q <= '0;
      out_q   <= '0;
      busy_q  <= 1'b0;
      diag_q  <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          st_q    <= mat_t'(blk_in);
          saved_q <= mat_t'(blk_in);
          cnt_q   <= rounds;
          diag_q  <= 1'b0;
          busy_q  <= 1'b1;
        end
      end else begin
        st_q   <= nxt_st;
        diag_q <= ~diag_q;
        if (diag_q) begin
          if (cnt_q <= DR_STEP) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            out_q  <= sum_st;
          end else begin
            cnt_q <= cnt_q - DR_STEP;
          end
        end
      end
    end
  end

  assign blk_out = BLK_W'(out_q);
  assign done    = done_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R5
  done_after_diag_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(busy_q && diag_q));

  // R6
  saved_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(saved_q));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && diag_q && cnt_q > DR_STEP) |=> (cnt_q == $past(cnt_q) - DR_STEP));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> $stable(out_q));
endmodule

// File: tb/tb_chacha_core.sv
module tb_chacha_core;
  localparam int CLK_PERIOD = 10;
  localparam int ROUND_W    = 8;
  localparam int WDOG       = 150000;

  logic               clk = 1'b0;
  logic               rst;
  logic               start;
  logic [ROUND_W-1:0] rounds;
  logic [511:0]       blk_in;
  logic [511:0]       blk_out;
  logic               done;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  chacha_core #(.ROUND_W(ROUND_W)) dut (
    .clk(clk), .rst(rst), .start(start), .rounds(rounds),
    .blk_in(blk_in), .blk_out(blk_out), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog R5 actual=%0d expected<=%0d", cyc, WDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] KV_IN [16] = '{
    32'h61707865, 32'h3320646e, 32'h79622d32, 32'h6b206574,
    32'h03020100, 32'h07060504, 32'h0b0a0908, 32'h0f0e0d0c,
    32'h13121110, 32'h17161514, 32'h1b1a1918, 32'h1f1e1d1c,
    32'h00000001, 32'h09000000, 32'h4a000000, 32'h00000000};
  localparam logic [31:0] KV_OUT [16] = '{
    32'he4e7f110, 32'h15593bd1, 32'h1fdd0f50, 32'hc47120a3,
    32'hc7f4d1c7, 32'h0368c033, 32'h9aaa2204, 32'h4e6cd4c3,
    32'h466482d2, 32'h09aa9f07, 32'h05d7c214, 32'ha2028bd9,
    32'hd19c12b5, 32'hb94e16de, 32'he883d0cb, 32'h4e3c50a2};

  logic [31:0] ms [16];

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic void mqr(input int a, input int b, input int c, input int d);
    ms[a] = ms[a] + ms[b]; ms[d] = rl(ms[d] ^ ms[a], 16);
    ms[c] = ms[c] + ms[d]; ms[b] = rl(ms[b] ^ ms[c], 12);
    ms[a] = ms[a] + ms[b]; ms[d] = rl(ms[d] ^ ms[a], 8);
    ms[c] = ms[c] + ms[d]; ms[b] = rl(ms[b] ^ ms[c], 7);
  endfunction

  function automatic int n_dr(input int r);
    int n = 1;
    int left = r;
    while (left > 2) begin
      left = left - 2;
      n = n + 1;
    end
    return n;
  endfunction

  function automatic logic [511:0] ref_block(input logic [511:0] x, input int r);
    logic [511:0] y;
    for (int i = 0; i < 16; i++) ms[i] = x[32*i +: 32];
    for (int k = 0; k < n_dr(r); k++) begin
      mqr(0, 4, 8, 12); mqr(1, 5, 9, 13); mqr(2, 6, 10, 14); mqr(3, 7, 11, 15);
      mqr(0, 5, 10, 15); mqr(1, 6, 11, 12); mqr(2, 7, 8, 13); mqr(3, 4, 9, 14);
    end
    for (int i = 0; i < 16; i++) y[32*i +: 32] = ms[i] + x[32*i +: 32];
    return y;
  endfunction

  function automatic logic [511:0] pack(input logic [31:0] w [16]);
    logic [511:0] y;
    for (int i = 0; i < 16; i++) y[32*i +: 32] = w[i];
    return y;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [511:0] act,
                     input logic [511:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_block(input logic [511:0] x, input int r,
                           output logic [511:0] res, output int lat);
    @(negedge clk);
    blk_in = x; rounds = ROUND_W'(r); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat = lat + 1;
    end
    res = blk_out;
  endtask

  initial begin
    logic [511:0] r20, r8, r12, r0, r1, r2, r3, r4, rin, got, held;
    int lat;
    int extra;
    void'($urandom(32'h5eed1234));
    rst = 1'b1; start = 1'b0; rounds = '0; blk_in = '0;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(done == 1'b0 && blk_out == '0, "R7 reset", {511'b0, done} | blk_out, '0);
    rst = 1'b0;

    // R8 known vector, R1 R2 R3 via model
    run_block(pack(KV_IN), 20, r20, lat);
    chk(r20 == pack(KV_OUT), "R8 vector20", r20, pack(KV_OUT));
    chk(r20 == ref_block(pack(KV_IN), 20), "R1 model20", r20, ref_block(pack(KV_IN), 20));
    chk(lat == 20, "R5 latency20", 512'(lat), 512'(20));

    // R7 hold
    repeat (7) @(negedge clk);
    chk(blk_out == r20 && !done, "R7 hold", blk_out, r20);

    run_block(pack(KV_IN), 8, r8, lat);
    chk(lat == 8, "R5 latency8", 512'(lat), 512'(8));
    run_block(pack(KV_IN), 12, r12, lat);
    chk(r8 != r20 && r12 != r20 && r8 != r12, "R8 distinct", r8, r12);
    chk(r12 == ref_block(pack(KV_IN), 12), "R2 model12", r12, ref_block(pack(KV_IN), 12));

    // R4 small counts
    run_block(pack(KV_IN), 0, r0, lat);
    chk(lat == 2, "R4 latency0", 512'(lat), 512'(2));
    run_block(pack(KV_IN), 1, r1, lat);
    run_block(pack(KV_IN), 2, r2, lat);
    chk(r0 == r1 && r1 == r2, "R4 zero-one-two", r0, r2);
    chk(r2 == ref_block(pack(KV_IN), 2), "R3 model2", r2, ref_block(pack(KV_IN), 2));
    run_block(pack(KV_IN), 3, r3, lat);
    chk(lat == 4, "R4 latency3", 512'(lat), 512'(4));
    run_block(pack(KV_IN), 4, r4, lat);
    chk(r3 == r4, "R4 three-four", r3, r4);

    // R6 start while busy
    rin = '0;
    for (int i = 0; i < 16; i++) rin[32*i +: 32] = $urandom;
    @(negedge clk);
    blk_in = rin; rounds = 8'd10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    repeat (2) begin @(negedge clk); lat = lat + 1; end
    blk_in = pack(KV_IN); rounds = 8'd2; start = 1'b1;
    @(negedge clk); lat = lat + 1;
    start = 1'b0;
    while (!done && lat < 1000) begin @(negedge clk); lat = lat + 1; end
    chk(lat == 10, "R6 latency kept", 512'(lat), 512'(10));
    chk(blk_out == ref_block(rin, 10), "R6 result kept", blk_out, ref_block(rin, 10));
    held = blk_out;
    extra = 0;
    repeat (40) begin @(negedge clk); if (done) extra = extra + 1; end
    chk(extra == 0 && blk_out == held, "R6 no extra done", 512'(extra), 512'(0));

    // R1 R5 random blocks
    for (int t = 0; t < 8; t++) begin
      int rr;
      rr = int'($urandom % 25);
      for (int i = 0; i < 16; i++) rin[32*i +: 32] = $urandom;
      run_block(rin, rr, got, lat);
      chk(got == ref_block(rin, rr), "R1 random", got, ref_block(rin, rr));
      chk(lat == 2 * n_dr(rr), "R5 random latency", 512'(lat), 512'(2 * n_dr(rr)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule